// File: doc/BRIEF.md
# Trap Return State Unit

This unit carries out the two privileged return operations of a RISC-V hart: the return from a machine-level trap and the return from a supervisor-level trap. The core presents a request that carries the return kind and the live architectural state. That state is the current privilege level, the virtualization flag, the machine and hypervisor status words, both saved exception PCs, the extension-present flags for compressed instructions, the hypervisor and physical memory protection, and the number of configured protection rules. The unit checks the request for faults in a fixed priority. In the next cycle it presents either the faulting cause with the state left unchanged, or the updated status words, the new privilege level, the new virtualization flag and the return PC.

When a return leaves or enters a virtual context, the unit raises a one-cycle bank-swap strobe. It does not move the hypervisor register banks itself. A small state machine with two states, `ST_IDLE` and `ST_COMMIT`, controls the registered result. On `IDLE->COMMIT` a request is sampled. `COMMIT->COMMIT` handles a back-to-back request. `COMMIT->IDLE` happens when no request follows. `res_valid` is high exactly while the machine is in `ST_COMMIT`.

Privilege encoding is user 0, supervisor 1, machine 3. Cause codes are: misaligned return address 0, instruction access fault 1, illegal instruction 2, virtual instruction 22. Status fields sit at their architectural positions. In the machine status word: supervisor enable bit 1, machine enable bit 3, supervisor previous-enable bit 5, machine previous-enable bit 7, supervisor previous-privilege bit 8, machine previous-privilege bits 12:11, trap-supervisor-return bit 22, machine previous-virtualization bit 39. In the hypervisor status word: supervisor previous-virtualization bit 7, virtual trap-supervisor-return bit 22.

Top module: `trp_unit`

## Requirements
- R1: While reset is asserted and after its release with no request, res_valid, res_exc and res_swap are 0 and res_priv is 3.
- R2: res_valid is 1 in the cycle after a cycle with req_valid high and 0 in the cycle after a cycle with req_valid low; res_pc is mepc for a machine return (req_sret=0) and sepc for a supervisor return (req_sret=1).
- R3: A machine return with cur_priv not equal to 3 faults with cause 2; this check outranks every other.
- R4: A supervisor return with cur_priv equal to 0 faults with cause 2.
- R5: When ext_c is 0 and bits 1:0 of the selected saved PC are not both 0, the return faults with cause 0, ranked below the privilege check and above all other checks; with ext_c set, the low bits are not checked.
- R6: A supervisor return with mstatus bit 22 set and cur_priv below 3 faults with cause 2, ranked above the virtual check of R7.
- R7: A supervisor return with ext_h=1, cur_virt=1 and hstatus bit 22 set faults with cause 22 when no earlier check fires; with cur_virt=0, hstatus bit 22 has no effect.
- R8: A machine return with ext_pmp=1, pmp_rules=0 and mstatus bits 12:11 not equal to 3 faults with cause 1; with rules configured or bits 12:11 equal to 3 it completes.
- R9: A completed machine return copies mstatus bit 7 into bit 3, sets bit 7, clears bits 12:11 and bit 39, and sets res_priv to the old bits 12:11.
- R10: A completed machine return with ext_h=1 sets res_virt and res_swap to the old mstatus bit 39; with ext_h=0, res_virt keeps cur_virt and res_swap is 0.
- R11: A completed supervisor return with ext_h=1 and cur_virt=0 sets res_priv to old mstatus bit 8, and sets res_virt and res_swap to old hstatus bit 7. It clears mstatus bit 8 and hstatus bit 7, copies mstatus bit 5 into bit 1, and sets bit 5.
- R12: Any other completed supervisor return copies mstatus bit 5 into bit 1, sets bit 5, clears bit 8, sets res_priv to old bit 8, keeps cur_virt and hstatus, and gives res_swap 0.
- R13: On a fault, res_mstatus, res_hstatus, res_priv and res_virt equal the sampled inputs and res_swap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Return request in this cycle |
| req_sret | input | 1 | 1 = supervisor return, 0 = machine return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| mstatus_in | input | 64 | Machine status word |
| hstatus_in | input | 64 | Hypervisor status word |
| mepc | input | XLEN | Saved machine exception PC |
| sepc | input | XLEN | Saved supervisor exception PC |
| ext_c | input | 1 | Compressed extension present |
| ext_h | input | 1 | Hypervisor extension present |
| ext_pmp | input | 1 | Memory protection implemented |
| pmp_rules | input | RULE_W | Number of configured protection rules |
| res_valid | output | 1 | Result valid (state machine in ST_COMMIT) |
| res_pc | output | XLEN | Return PC |
| res_mstatus | output | 64 | Updated machine status word |
| res_hstatus | output | 64 | Updated hypervisor status word |
| res_priv | output | 2 | New privilege level |
| res_virt | output | 1 | New virtualization flag |
| res_exc | output | 1 | Fault raised |
| res_cause | output | CAUSE_W | Fault cause code |
| res_swap | output | 1 | Request to swap hypervisor register banks |

## Verification
The checker's properties assume that the fields the core feeds in are legal. The machine previous-privilege field never holds the reserved value 2, and cur_priv is never 2. The fault-path property compares the results with the inputs sampled one cycle earlier, so it depends on the inputs being held stable while req_valid is high. The bench drives every vector at the falling edge and keeps it for the whole sampled cycle. All stimulus uses only privilege values 0, 1 and 3.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_M = 2'd3;

    localparam int STW = 64;

    // machine status word fields
    localparam int B_SIE    = 1;
    localparam int B_MIE    = 3;
    localparam int B_SPIE   = 5;
    localparam int B_MPIE   = 7;
    localparam int B_SPP    = 8;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = 12;
    localparam int B_TSR    = 22;
    localparam int B_MPV    = 39;

    // hypervisor status word fields
    localparam int H_SPV    = 7;
    localparam int H_VTSR   = 22;

    localparam int C_MISALIGN = 0;
    localparam int C_ACCESS   = 1;
    localparam int C_ILLEGAL  = 2;
    localparam int C_VIRT     = 22;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } fsm_e;

endpackage

// File: rtl/trp_check.sv
module trp_check
    import trp_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int RULE_W  = 7,
    parameter int CAUSE_W = 6
) (
    input  logic               is_sret,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [STW-1:0]     ms,
    input  logic [STW-1:0]     hs,
    input  logic [XLEN-1:0]    epc,
    input  logic               ext_c,
    input  logic               ext_h,
    input  logic               ext_pmp,
    input  logic [RULE_W-1:0]  rules,
    output logic               exc,
    output logic [CAUSE_W-1:0] cause
);

    logic priv_ok;
    logic misal;

    assign priv_ok = is_sret ? (priv >= LVL_S) : (priv == LVL_M);
    assign misal   = !ext_c && (epc[1:0] != 2'b00);

    // fixed priority: privilege, alignment, trap-return, virtual trap-return / protection
    always_comb begin
        exc   = 1'b0;
        cause = '0;
        if (!priv_ok) begin
            exc   = 1'b1;
            cause = CAUSE_W'(C_ILLEGAL);
        end else if (misal) begin
            exc   = 1'b1;
            cause = CAUSE_W'(C_MISALIGN);
        end else if (is_sret) begin
            if (ms[B_TSR] && (priv != LVL_M)) begin
                exc   = 1'b1;
                cause = CAUSE_W'(C_ILLEGAL);
            end else if (ext_h && virt && hs[H_VTSR]) begin
                exc   = 1'b1;
                cause = CAUSE_W'(C_VIRT);
            end
        end else if (ext_pmp && (rules == '0) && (ms[B_MPP_HI:B_MPP_LO] != LVL_M)) begin
            exc   = 1'b1;
            cause = CAUSE_W'(C_ACCESS);
        end
    end

endmodule

// File: rtl/trp_update.sv
module trp_update
    import trp_pkg::*;
(
    input  logic           is_sret,
    input  logic [1:0]     priv,
    input  logic           virt,
    input  logic [STW-1:0] ms,
    input  logic [STW-1:0] hs,
    input  logic           ext_h,
    output logic [STW-1:0] nms,
    output logic [STW-1:0] nhs,
    output logic [1:0]     npriv,
    output logic           nvirt,
    output logic           nswap
);

    always_comb begin
        nms   = ms;
        nhs   = hs;
        npriv = priv;
        nvirt = virt;
        nswap = 1'b0;
        if (!is_sret) begin
            npriv                  = ms[B_MPP_HI:B_MPP_LO];
            nms[B_MIE]             = ms[B_MPIE];
            nms[B_MPIE]            = 1'b1;
            nms[B_MPP_HI:B_MPP_LO] = LVL_U;
            nms[B_MPV]             = 1'b0;
            if (ext_h) begin
                nvirt = ms[B_MPV];
                nswap = ms[B_MPV];
            end
        end else if (ext_h && !virt) begin
            npriv       = {1'b0, ms[B_SPP]};
            nvirt       = hs[H_SPV];
            nswap       = hs[H_SPV];
            nhs[H_SPV]  = 1'b0;
            nms[B_SPP]  = 1'b0;
            nms[B_SIE]  = ms[B_SPIE];
            nms[B_SPIE] = 1'b1;
        end else begin
            npriv       = {1'b0, ms[B_SPP]};
            nms[B_SIE]  = ms[B_SPIE];
            nms[B_SPIE] = 1'b1;
            nms[B_SPP]  = 1'b0;
        end
    end

endmodule

// File: rtl/trp_unit.sv
module trp_unit
    import trp_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int RULE_W  = 7,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_sret,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic [63:0]        mstatus_in,
    input  logic [63:0]        hstatus_in,
    input  logic [XLEN-1:0]    mepc,
    input  logic [XLEN-1:0]    sepc,
    input  logic               ext_c,
    input  logic               ext_h,
    input  logic               ext_pmp,
    input  logic [RULE_W-1:0]  pmp_rules,
    output logic               res_valid,
    output logic [XLEN-1:0]    res_pc,
    output logic [63:0]        res_mstatus,
    output logic [63:0]        res_hstatus,
    output logic [1:0]         res_priv,
    output logic               res_virt,
    output logic               res_exc,
    output logic [CAUSE_W-1:0] res_cause,
    output logic               res_swap
);

    fsm_e state_q, state_d;

    logic [XLEN-1:0]    sel_pc;
    logic               chk_exc;
    logic [CAUSE_W-1:0] chk_cause;
    logic [STW-1:0]     upd_ms, upd_hs;
    logic [1:0]         upd_priv;
    logic               upd_virt, upd_swap;

    assign sel_pc = req_sret ? sepc : mepc;

    trp_check #(
        .XLEN(XLEN), .RULE_W(RULE_W), .CAUSE_W(CAUSE_W)
    ) u_check (
        .is_sret (req_sret),
        .priv    (cur_priv),
        .virt    (cur_virt),
        .ms      (mstatus_in),
        .hs      (hstatus_in),
        .epc     (sel_pc),
        .ext_c   (ext_c),
        .ext_h   (ext_h),
        .ext_pmp (ext_pmp),
        .rules   (pmp_rules),
        .exc     (chk_exc),
        .cause   (chk_cause)
    );

    trp_update u_update (
        .is_sret (req_sret),
        .priv    (cur_priv),
        .virt    (cur_virt),
        .ms      (mstatus_in),
        .hs      (hstatus_in),
        .ext_h   (ext_h),
        .nms     (upd_ms),
        .nhs     (upd_hs),
        .npriv   (upd_priv),
        .nvirt   (upd_virt),
        .nswap   (upd_swap)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = req_valid ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_COMMIT);

    // registered commit: a fault leaves every piece of state as sampled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_pc      <= '0;
            res_mstatus <= '0;
            res_hstatus <= '0;
            res_priv    <= LVL_M;
            res_virt    <= 1'b0;
            res_exc     <= 1'b0;
            res_cause   <= '0;
            res_swap    <= 1'b0;
        end else if (req_valid) begin
            res_pc    <= sel_pc;
            res_exc   <= chk_exc;
            res_cause <= chk_cause;
            if (chk_exc) begin
                res_mstatus <= mstatus_in;
                res_hstatus <= hstatus_in;
                res_priv    <= cur_priv;
                res_virt    <= cur_virt;
                res_swap    <= 1'b0;
            end else begin
                res_mstatus <= upd_ms;
                res_hstatus <= upd_hs;
                res_priv    <= upd_priv;
                res_virt    <= upd_virt;
                res_swap    <= upd_swap;
            end
        end else begin
            res_swap <= 1'b0;
        end
    end

endmodule

// File: rtl/trp_unit_chk.sv
module trp_unit_chk #(
    parameter int CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_sret,
    input logic [1:0]         cur_priv,
    input logic               cur_virt,
    input logic [63:0]        mstatus_in,
    input logic [63:0]        hstatus_in,
    input logic               res_valid,
    input logic [63:0]        res_mstatus,
    input logic [63:0]        res_hstatus,
    input logic [1:0]         res_priv,
    input logic               res_virt,
    input logic               res_exc,
    input logic [CAUSE_W-1:0] res_cause,
    input logic               res_swap
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_mret_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(req_sret) && ($past(cur_priv) != 2'd3))
        |-> (res_exc && (res_cause == CAUSE_W'(2))));

    assert_sret_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_sret) && ($past(cur_priv) == 2'd0))
        |-> (res_exc && (res_cause == CAUSE_W'(2))));

    assert_mret_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_exc && !$past(req_sret))
        |-> (res_mstatus[7] && (res_mstatus[12:11] == 2'd0) && !res_mstatus[39]
             && (res_priv == $past(mstatus_in[12:11]))));

    assert_swap_virt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_swap |-> (res_valid && res_virt));

    assert_fault_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_exc)
        |-> (!res_swap && (res_priv == $past(cur_priv)) && (res_virt == $past(cur_virt))
             && (res_mstatus == $past(mstatus_in)) && (res_hstatus == $past(hstatus_in))));

endmodule

bind trp_unit trp_unit_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_sret    (req_sret),
    .cur_priv    (cur_priv),
    .cur_virt    (cur_virt),
    .mstatus_in  (mstatus_in),
    .hstatus_in  (hstatus_in),
    .res_valid   (res_valid),
    .res_mstatus (res_mstatus),
    .res_hstatus (res_hstatus),
    .res_priv    (res_priv),
    .res_virt    (res_virt),
    .res_exc     (res_exc),
    .res_cause   (res_cause),
    .res_swap    (res_swap)
);

// File: tb/trp_unit_bench.sv
module trp_unit_bench;

    localparam int XLEN = 64;
    localparam int RULE_W = 7;
    localparam int CAUSE_W = 6;
    localparam logic [63:0] OTHER_PC = 64'hDEAD0;

    typedef struct packed {
        logic        kind;   // 1 = supervisor return
        logic [1:0]  priv;
        logic        virt;
        logic [63:0] ms;
        logic [63:0] hs;
        logic [63:0] epc;
        logic        c;
        logic        h;
        logic        pmp;
        logic [6:0]  rules;
        logic [3:0]  rq;
        logic        e_exc;
        logic [5:0]  e_cause;
        logic [1:0]  e_priv;
        logic        e_virt;
        logic        e_swap;
        logic [63:0] e_ms;
        logic [63:0] e_hs;
    } vec_t;

    localparam int NV = 19;
    // R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 are covered by the rows below
    localparam vec_t VECS [NV] = '{
        '{1'b0,2'd3,1'b0,64'h880,64'h0,64'h1000,1'b0,1'b0,1'b0,7'd0,4'd9,1'b0,6'd0,2'd1,1'b0,1'b0,64'h88,64'h0},
        '{1'b0,2'd1,1'b0,64'h880,64'h0,64'h1000,1'b0,1'b0,1'b0,7'd0,4'd3,1'b1,6'd2,2'd1,1'b0,1'b0,64'h880,64'h0},
        '{1'b0,2'd3,1'b0,64'h880,64'h0,64'h1002,1'b0,1'b0,1'b0,7'd0,4'd5,1'b1,6'd0,2'd3,1'b0,1'b0,64'h880,64'h0},
        '{1'b0,2'd3,1'b0,64'h1808,64'h0,64'h1002,1'b1,1'b0,1'b0,7'd0,4'd5,1'b0,6'd0,2'd3,1'b0,1'b0,64'h80,64'h0},
        '{1'b0,2'd3,1'b0,64'h800,64'h0,64'h1000,1'b0,1'b0,1'b1,7'd0,4'd8,1'b1,6'd1,2'd3,1'b0,1'b0,64'h800,64'h0},
        '{1'b0,2'd3,1'b0,64'h1800,64'h0,64'h1000,1'b0,1'b0,1'b1,7'd0,4'd8,1'b0,6'd0,2'd3,1'b0,1'b0,64'h80,64'h0},
        '{1'b0,2'd3,1'b0,64'h0,64'h0,64'h1000,1'b0,1'b0,1'b1,7'd4,4'd8,1'b0,6'd0,2'd0,1'b0,1'b0,64'h80,64'h0},
        '{1'b0,2'd3,1'b0,64'h8000000880,64'h0,64'h1000,1'b0,1'b1,1'b0,7'd0,4'd10,1'b0,6'd0,2'd1,1'b1,1'b1,64'h88,64'h0},
        '{1'b0,2'd3,1'b0,64'h8000000800,64'h0,64'h1000,1'b0,1'b0,1'b0,7'd0,4'd10,1'b0,6'd0,2'd1,1'b0,1'b0,64'h80,64'h0},
        '{1'b0,2'd1,1'b0,64'h880,64'h0,64'h1002,1'b0,1'b0,1'b0,7'd0,4'd3,1'b1,6'd2,2'd1,1'b0,1'b0,64'h880,64'h0},
        '{1'b1,2'd0,1'b0,64'h20,64'h0,64'h2000,1'b0,1'b0,1'b0,7'd0,4'd4,1'b1,6'd2,2'd0,1'b0,1'b0,64'h20,64'h0},
        '{1'b1,2'd1,1'b0,64'h400000,64'h0,64'h2001,1'b0,1'b0,1'b0,7'd0,4'd5,1'b1,6'd0,2'd1,1'b0,1'b0,64'h400000,64'h0},
        '{1'b1,2'd1,1'b0,64'h400000,64'h0,64'h2000,1'b0,1'b0,1'b0,7'd0,4'd6,1'b1,6'd2,2'd1,1'b0,1'b0,64'h400000,64'h0},
        '{1'b1,2'd3,1'b0,64'h400120,64'h0,64'h2000,1'b0,1'b0,1'b0,7'd0,4'd12,1'b0,6'd0,2'd1,1'b0,1'b0,64'h400022,64'h0},
        '{1'b1,2'd1,1'b1,64'h0,64'h400000,64'h2000,1'b0,1'b1,1'b0,7'd0,4'd7,1'b1,6'd22,2'd1,1'b1,1'b0,64'h0,64'h400000},
        '{1'b1,2'd1,1'b1,64'h400000,64'h400000,64'h2000,1'b0,1'b1,1'b0,7'd0,4'd6,1'b1,6'd2,2'd1,1'b1,1'b0,64'h400000,64'h400000},
        '{1'b1,2'd3,1'b0,64'h120,64'h400080,64'h2000,1'b0,1'b1,1'b0,7'd0,4'd11,1'b0,6'd0,2'd1,1'b1,1'b1,64'h22,64'h400000},
        '{1'b1,2'd1,1'b0,64'h102,64'h0,64'h2000,1'b0,1'b1,1'b0,7'd0,4'd11,1'b0,6'd0,2'd1,1'b0,1'b0,64'h20,64'h0},
        '{1'b1,2'd1,1'b1,64'h20,64'h80,64'h2000,1'b0,1'b1,1'b0,7'd0,4'd12,1'b0,6'd0,2'd0,1'b1,1'b0,64'h22,64'h80}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_sret = 1'b0;
    logic [1:0]         cur_priv = 2'd3;
    logic               cur_virt = 1'b0;
    logic [63:0]        mstatus_in = '0;
    logic [63:0]        hstatus_in = '0;
    logic [XLEN-1:0]    mepc = '0;
    logic [XLEN-1:0]    sepc = '0;
    logic               ext_c = 1'b0;
    logic               ext_h = 1'b0;
    logic               ext_pmp = 1'b0;
    logic [RULE_W-1:0]  pmp_rules = '0;
    logic               res_valid;
    logic [XLEN-1:0]    res_pc;
    logic [63:0]        res_mstatus;
    logic [63:0]        res_hstatus;
    logic [1:0]         res_priv;
    logic               res_virt;
    logic               res_exc;
    logic [CAUSE_W-1:0] res_cause;
    logic               res_swap;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trp_unit #(.XLEN(XLEN), .RULE_W(RULE_W), .CAUSE_W(CAUSE_W)) u_trp_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sret(req_sret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_in(mstatus_in),
        .hstatus_in(hstatus_in), .mepc(mepc), .sepc(sepc), .ext_c(ext_c),
        .ext_h(ext_h), .ext_pmp(ext_pmp), .pmp_rules(pmp_rules),
        .res_valid(res_valid), .res_pc(res_pc), .res_mstatus(res_mstatus),
        .res_hstatus(res_hstatus), .res_priv(res_priv), .res_virt(res_virt),
        .res_exc(res_exc), .res_cause(res_cause), .res_swap(res_swap)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1", "valid in reset", 64'(res_valid), 64'd0);
        chk("R1", "priv in reset", 64'(res_priv), 64'd3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid idle", 64'(res_valid), 64'd0);
        chk("R1", "exc idle", 64'(res_exc), 64'd0);
        chk("R1", "swap idle", 64'(res_swap), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            req_valid  = 1'b1;
            req_sret   = VECS[i].kind;
            cur_priv   = VECS[i].priv;
            cur_virt   = VECS[i].virt;
            mstatus_in = VECS[i].ms;
            hstatus_in = VECS[i].hs;
            mepc       = VECS[i].kind ? OTHER_PC : VECS[i].epc;
            sepc       = VECS[i].kind ? VECS[i].epc : OTHER_PC;
            ext_c      = VECS[i].c;
            ext_h      = VECS[i].h;
            ext_pmp    = VECS[i].pmp;
            pmp_rules  = VECS[i].rules;
            @(negedge clk);
            chk("R2", "valid", 64'(res_valid), 64'd1);
            chk("R2", "pc select", res_pc, VECS[i].epc);
            chk(tg, "exc", 64'(res_exc), 64'(VECS[i].e_exc));
            if (VECS[i].e_exc) chk(tg, "cause", 64'(res_cause), 64'(VECS[i].e_cause));
            chk(tg, "priv", 64'(res_priv), 64'(VECS[i].e_priv));
            chk(tg, "virt", 64'(res_virt), 64'(VECS[i].e_virt));
            chk(tg, "swap", 64'(res_swap), 64'(VECS[i].e_swap));
            chk(tg, "mstatus", res_mstatus, VECS[i].e_ms);
            chk(tg, "hstatus", res_hstatus, VECS[i].e_hs);
        end

        // R2: result drops and swap strobe clears once requests stop
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2", "valid after idle", 64'(res_valid), 64'd0);
        chk("R10", "swap after idle", 64'(res_swap), 64'd0);

        // R1: reset mid-run returns outputs to reset state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "priv after reset", 64'(res_priv), 64'd3);
        chk("R1", "exc after reset", 64'(res_exc), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule